// File: doc/BRIEF.md
# Repeated String Store Engine

This block carries out a string store. It writes the accumulator value, one element at a time, to memory at a segment base plus a destination index. A start pulse delivers a decoded command together with the operand values. The command gives the element size (byte, word or doubleword), the address width (16 or 32 bit), a direction bit and a repeat bit. The operand values are the accumulator, the segment base, the destination index and the count. The engine presents each element on a valid/ready write port. After every accepted write it advances the index by the element size, in the direction the direction bit selects.

Without the repeat bit, exactly one element is stored. With the repeat bit, the engine stores as many elements as the count register holds and decrements the count once per element. A zero count stores nothing. In 16-bit address mode only the low halves of the index and of the count take part: they wrap within 16 bits and their upper halves are carried through unchanged. A one-cycle done pulse reports completion, and the final index and count are on the outputs in that same cycle. The engine keeps no status flags.

Top module: `strstore_engine`

## Requirements
- R1: `cmd_sz` selects the element size: 0 = byte, 1 = word, 2 = doubleword. `wr_be` is 4'b0001, 4'b0011 or 4'b1111 respectively. Lane 0 (`wr_data[7:0]`) is the byte at `wr_addr`, and the data is the low 1, 2 or 4 bytes of `acc` in little-endian order, with unused lanes zero.
- R2: `wr_addr` = `seg_base` + index, modulo 2^32. The index is the whole 32-bit `dst_idx` when `cmd_a32`=1, and its low 16 bits zero-extended when `cmd_a32`=0.
- R3: After each accepted element the index rises by the step (1, 2 or 4 for byte, word or doubleword) when `cmd_down`=0, and falls by the step when `cmd_down`=1.
- R4: With `cmd_a32`=0 only `dst_idx_out[15:0]` changes, wrapping modulo 65536. `dst_idx_out[31:16]` keeps its start value.
- R5: With `cmd_rep`=0 exactly one write is issued, and `cnt_out` equals the start count when the operation finishes.
- R6: With `cmd_rep`=1 the number of writes equals the start count: all 32 bits when `cmd_a32`=1, the low 16 bits otherwise. The count falls by 1 per accepted element and ends at zero. In 16-bit mode `cnt_out[31:16]` keeps its start value.
- R7: With `cmd_rep`=1 and a zero start count, no write is issued, `done` is high in the first cycle after the start edge, and the index and count are unchanged.
- R8: `done` is high for exactly one cycle, the cycle after the final accepted write. `dst_idx_out` and `cnt_out` hold the final values in that cycle, and `busy` is low in the cycle after.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_be` stay unchanged.
- R10: A `start` raised while `busy` is high is ignored: the running operation's writes and final values are unaffected.
- R11: After reset `busy`, `wr_valid` and `done` are low, and `dst_idx_out` and `cnt_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| cmd_sz | input | 2 | Element size code |
| cmd_a32 | input | 1 | 1 = 32-bit address and count, 0 = 16-bit |
| cmd_down | input | 1 | 1 = index decrements, 0 = increments |
| cmd_rep | input | 1 | Repeat over the count register |
| acc | input | 32 | Accumulator value to store |
| seg_base | input | 32 | Destination segment base |
| dst_idx | input | 32 | Start destination index |
| cnt_in | input | 32 | Start count |
| busy | output | 1 | Operation in progress |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 32 | Byte address of lane 0 |
| wr_data | output | 32 | Write data, lane 0 in bits 7:0 |
| wr_be | output | 4 | Byte lane enables |
| done | output | 1 | One-cycle completion pulse |
| dst_idx_out | output | 32 | Current or final destination index |
| cnt_out | output | 32 | Current or final count |

## Verification
`wr_valid` and the first element appear one edge after `start` is sampled. Each later element appears one edge after the previous one is accepted. `done` follows the final acceptance by one edge. With a zero repeat count, `done` follows the start edge by one edge. The bench drives at the falling edge and samples at the next falling edge, so every result is read exactly one register stage after its cause. Its model steps the expected index, count and element number only on cycles where it has asserted `wr_ready` while `wr_valid` was seen high. It flags a `done` that comes late, comes early, or lasts more than one cycle.

// File: rtl/strstore_pkg.sv
package strstore_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = WORD_W / 2;
    localparam int unsigned LANES  = WORD_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } elem_sz_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } eng_state_e;

    typedef struct packed {
        elem_sz_e sz;
        logic     a32;
        logic     down;
        logic     rep;
    } str_cmd_t;

    // Bytes per element; the reserved code behaves as a doubleword.
    function automatic logic [WORD_W-1:0] step_of(elem_sz_e sz);
        case (sz)
            SZ_BYTE: return WORD_W'(1);
            SZ_WORD: return WORD_W'(2);
            default: return WORD_W'(4);
        endcase
    endfunction

    function automatic int unsigned lanes_of(elem_sz_e sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_WORD: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic cnt_is_zero(logic a32, logic [WORD_W-1:0] c);
        return a32 ? (c == '0) : (c[HALF_W-1:0] == '0);
    endfunction

endpackage

// File: rtl/strstore_lanes.sv
module strstore_lanes
    import strstore_pkg::*;
#(
    parameter int unsigned NLANES = LANES
) (
    input  elem_sz_e           sz,
    input  logic [8*NLANES-1:0] acc,
    output logic [NLANES-1:0]   be,
    output logic [8*NLANES-1:0] data
);
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic en;
        assign en = (g < lanes_of(sz));
        assign be[g] = en;
        assign data[8*g +: 8] = en ? acc[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/strstore_step.sv
module strstore_step
    import strstore_pkg::*;
(
    input  str_cmd_t           cmd,
    input  logic [WORD_W-1:0]  base,
    input  logic [WORD_W-1:0]  idx,
    input  logic [WORD_W-1:0]  cnt,
    output logic [WORD_W-1:0]  addr,
    output logic [WORD_W-1:0]  nxt_idx,
    output logic [WORD_W-1:0]  nxt_cnt,
    output logic               last
);
    logic [WORD_W-1:0] step;
    logic [WORD_W-1:0] eff_idx;
    logic [WORD_W-1:0] wide_idx;
    logic [HALF_W-1:0] narrow_idx;
    logic [WORD_W-1:0] dec_cnt;

    always_comb begin
        step       = step_of(cmd.sz);
        eff_idx    = cmd.a32 ? idx : {{HALF_W{1'b0}}, idx[HALF_W-1:0]};
        addr       = base + eff_idx;
        wide_idx   = cmd.down ? (idx - step) : (idx + step);
        narrow_idx = cmd.down ? (idx[HALF_W-1:0] - step[HALF_W-1:0])
                              : (idx[HALF_W-1:0] + step[HALF_W-1:0]);
        nxt_idx    = cmd.a32 ? wide_idx : {idx[WORD_W-1:HALF_W], narrow_idx};
        dec_cnt    = cmd.a32 ? (cnt - 1'b1)
                             : {cnt[WORD_W-1:HALF_W], cnt[HALF_W-1:0] - 1'b1};
        nxt_cnt    = cmd.rep ? dec_cnt : cnt;
        last       = !cmd.rep || cnt_is_zero(cmd.a32, dec_cnt);
    end
endmodule

// File: rtl/strstore_engine.sv
module strstore_engine
    import strstore_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  cmd_sz,
    input  logic        cmd_a32,
    input  logic        cmd_down,
    input  logic        cmd_rep,
    input  logic [31:0] acc,
    input  logic [31:0] seg_base,
    input  logic [31:0] dst_idx,
    input  logic [31:0] cnt_in,
    output logic        busy,
    output logic        wr_valid,
    input  logic        wr_ready,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data,
    output logic [3:0]  wr_be,
    output logic        done,
    output logic [31:0] dst_idx_out,
    output logic [31:0] cnt_out
);
    eng_state_e        state_q;
    str_cmd_t          cmd_q;
    str_cmd_t          cmd_in;
    logic [WORD_W-1:0] acc_q, base_q, idx_q, cnt_q;
    logic [WORD_W-1:0] nxt_idx, nxt_cnt;
    logic              last_elem;

    assign cmd_in = '{sz: elem_sz_e'(cmd_sz), a32: cmd_a32, down: cmd_down, rep: cmd_rep};

    strstore_step u_step (
        .cmd     (cmd_q),
        .base    (base_q),
        .idx     (idx_q),
        .cnt     (cnt_q),
        .addr    (wr_addr),
        .nxt_idx (nxt_idx),
        .nxt_cnt (nxt_cnt),
        .last    (last_elem)
    );

    strstore_lanes #(.NLANES(LANES)) u_lanes (
        .sz   (cmd_q.sz),
        .acc  (acc_q),
        .be   (wr_be),
        .data (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            acc_q   <= '0;
            base_q  <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q  <= cmd_in;
                        acc_q  <= acc;
                        base_q <= seg_base;
                        idx_q  <= dst_idx;
                        cnt_q  <= cnt_in;
                        state_q <= (cmd_rep && cnt_is_zero(cmd_a32, cnt_in))
                                   ? ST_DONE : ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (wr_ready) begin
                        idx_q <= nxt_idx;
                        cnt_q <= nxt_cnt;
                        if (last_elem) state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign wr_valid    = (state_q == ST_WRITE);
    assign done        = (state_q == ST_DONE);
    assign dst_idx_out = idx_q;
    assign cnt_out     = cnt_q;
endmodule

module strstore_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [31:0] wr_addr,
    input logic [31:0] wr_data,
    input logic [3:0]  wr_be,
    input logic        done,
    input logic [31:0] dst_idx_out,
    input logic [31:0] cnt_out,
    input logic [1:0]  op_sz,
    input logic        op_a32,
    input logic        op_down,
    input logic        op_rep
);
    logic [31:0] mag, delta;
    assign mag   = (op_sz == 2'd0) ? 32'd1 : (op_sz == 2'd1) ? 32'd2 : 32'd4;
    assign delta = op_down ? (32'd0 - mag) : mag;

    a_r1_be_shape: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_be == 4'b0001 || wr_be == 4'b0011 || wr_be == 4'b1111));

    a_r3_idx_step: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && op_a32) |=> dst_idx_out == $past(dst_idx_out + delta));

    a_r4_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && !op_a32) |=> dst_idx_out[31:16] == $past(dst_idx_out[31:16]));

    a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && !op_rep) |=> (done && !wr_valid));

    a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && op_rep && op_a32) |=> cnt_out == $past(cnt_out - 32'd1));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_hold_request: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!wr_valid && !done));
endmodule

bind strstore_engine strstore_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_be       (wr_be),
    .done        (done),
    .dst_idx_out (dst_idx_out),
    .cnt_out     (cnt_out),
    .op_sz       (cmd_q.sz),
    .op_a32      (cmd_q.a32),
    .op_down     (cmd_q.down),
    .op_rep      (cmd_q.rep)
);

// File: tb/strstore_engine_test.sv
module strstore_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  cmd_sz = '0;
    logic        cmd_a32 = 1'b0, cmd_down = 1'b0, cmd_rep = 1'b0;
    logic [31:0] acc = '0, seg_base = '0, dst_idx = '0, cnt_in = '0;
    logic        busy, wr_valid, done;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr, wr_data, dst_idx_out, cnt_out;
    logic [3:0]  wr_be;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strstore_engine uut (
        .clk(clk), .rst(rst), .start(start), .cmd_sz(cmd_sz), .cmd_a32(cmd_a32),
        .cmd_down(cmd_down), .cmd_rep(cmd_rep), .acc(acc), .seg_base(seg_base),
        .dst_idx(dst_idx), .cnt_in(cnt_in), .busy(busy), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .done(done), .dst_idx_out(dst_idx_out), .cnt_out(cnt_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] f_step(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    function automatic logic [31:0] f_next_idx(input logic [31:0] i, input logic [1:0] sz,
                                               input logic dn, input logic a32);
        logic [31:0] s = f_step(sz);
        logic [15:0] lo;
        if (a32) return dn ? i - s : i + s;
        lo = dn ? i[15:0] - s[15:0] : i[15:0] + s[15:0];
        return {i[31:16], lo};
    endfunction

    function automatic logic [3:0] f_be(input logic [1:0] sz);
        return (sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111;
    endfunction

    function automatic logic [31:0] f_data(input logic [31:0] a, input logic [1:0] sz);
        return (sz == 2'd0) ? {24'h0, a[7:0]} : (sz == 2'd1) ? {16'h0, a[15:0]} : a;
    endfunction

    task automatic run_op(input logic [1:0] sz, input logic a32, input logic dn, input logic rep,
                          input logic [31:0] av, input logic [31:0] bv, input logic [31:0] iv,
                          input logic [31:0] cv, input int rdy_pct, input logic poke);
        logic [31:0] midx = iv;
        logic [31:0] mcnt = cv;
        int n = rep ? (a32 ? int'(cv) : int'(cv[15:0])) : 1;
        int e = 0;
        int cyc = 0;
        logic last_acc = 1'b0;
        @(negedge clk);
        cmd_sz = sz; cmd_a32 = a32; cmd_down = dn; cmd_rep = rep;
        acc = av; seg_base = bv; dst_idx = iv; cnt_in = cv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (last_acc) chk("R8", "done after final accept", {31'b0, done}, 32'd1);
            if (n == 0 && cyc == 0) chk("R7", "done right after zero-count start", {31'b0, done}, 32'd1);
            if (done) begin
                chk(rep ? "R6" : "R5", "element count", e, n);
                chk(a32 ? "R3" : "R4", "final index", dst_idx_out, midx);
                chk(rep ? "R6" : "R5", "final count", cnt_out, mcnt);
                chk("R7", "no write with done", {31'b0, wr_valid}, 32'd0);
                break;
            end
            chk("R10", "busy during op", {31'b0, busy}, 32'd1);
            chk("R6", "write pending", {31'b0, wr_valid}, 32'd1);
            if (wr_valid) begin
                chk("R2", "address", wr_addr, bv + (a32 ? midx : {16'h0, midx[15:0]}));
                chk("R1", "data", wr_data, f_data(av, sz));
                chk("R1", "byte enables", {28'h0, wr_be}, {28'h0, f_be(sz)});
                wr_ready = (($urandom % 100) < rdy_pct);
                if (wr_ready) begin
                    e++;
                    midx = f_next_idx(midx, sz, dn, a32);
                    if (rep) mcnt = a32 ? mcnt - 1 : {mcnt[31:16], mcnt[15:0] - 16'd1};
                    last_acc = (e == n);
                end
            end
            if (poke) begin
                start = 1'b1; cmd_sz = 2'($urandom); cmd_a32 = ~a32; cmd_down = ~dn;
                cmd_rep = 1'b1; acc = $urandom; seg_base = $urandom; dst_idx = $urandom; cnt_in = 32'd9;
            end
            cyc++;
            if (cyc > 2000) begin
                chk("R8", "operation never finished", 32'd0, 32'd1);
                break;
            end
            @(negedge clk);
            wr_ready = 1'b0;
            start = 1'b0;
        end
        wr_ready = 1'b0;
        start = 1'b0;
        @(negedge clk);
        chk("R8", "idle after done", {31'b0, busy}, 32'd0);
        chk("R8", "done one cycle", {31'b0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "busy after reset", {31'b0, busy}, 32'd0);
        chk("R11", "wr_valid after reset", {31'b0, wr_valid}, 32'd0);
        chk("R11", "done after reset", {31'b0, done}, 32'd0);
        chk("R11", "index after reset", dst_idx_out, 32'd0);
        chk("R11", "count after reset", cnt_out, 32'd0);

        // R4: 16-bit byte store wraps the low half upward
        run_op(2'd0, 1'b0, 1'b0, 1'b0, 32'hDEADBEEF, 32'h0001_0000, 32'h1234_FFFF, 32'd5, 100, 1'b0);
        // R3: 32-bit doubleword store wraps below zero
        run_op(2'd2, 1'b1, 1'b1, 1'b0, 32'hCAFEF00D, 32'h1000_0000, 32'h0000_0002, 32'd0, 100, 1'b0);
        // R7: repeat with zero low count in 16-bit mode
        run_op(2'd1, 1'b0, 1'b0, 1'b1, 32'h11223344, 32'h0, 32'h0000_0100, 32'h7777_0000, 100, 1'b0);
        // R7: repeat with zero 32-bit count
        run_op(2'd2, 1'b1, 1'b0, 1'b1, 32'h55667788, 32'h0, 32'h0000_0400, 32'h0, 100, 1'b0);
        // R6: 16-bit count keeps upper half, word store downward with stalls
        run_op(2'd1, 1'b0, 1'b1, 1'b1, 32'hA5A5_1357, 32'h0002_0000, 32'hFFFF_0002, 32'hABCD_0003, 50, 1'b0);
        // R5: single store leaves the count alone; R10: start pokes ignored
        run_op(2'd2, 1'b1, 1'b0, 1'b0, 32'h0BADC0DE, 32'h0, 32'h0000_1000, 32'd5, 40, 1'b1);
        // R9/R10: repeated byte store under heavy back-pressure and pokes
        run_op(2'd0, 1'b1, 1'b0, 1'b1, 32'h0000_00AB, 32'h2000_0000, 32'hFFFF_FFFE, 32'd4, 25, 1'b1);

        for (int k = 0; k < 300; k++) begin
            logic [1:0]  sz  = 2'($urandom % 3);
            logic        a32 = 1'($urandom);
            logic [31:0] cv  = a32 ? ($urandom % 6) : {16'($urandom), 16'($urandom % 6)};
            run_op(sz, a32, 1'($urandom), 1'($urandom), $urandom, $urandom, $urandom, cv,
                   30 + int'($urandom % 71), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule